// File: doc/BRIEF.md
# Multi-lane packet framer and striper

This block builds packets on the transmit side of a serial memory link. It takes one payload per handshake. A payload is either a memory command word or a 64-byte data block with its 8 ECC bytes. The block places a two-byte header in front of the payload. It then appends a 16-bit CRC and a one-byte end marker. The finished packet is spread byte by byte across several parallel lanes. All lanes carry their bytes in the same cycle.

Each lane delivers one byte per symbol clock. Each byte has a flag that tells the downstream 8b/10b encoder whether it is a control character or data. Command packets use three lanes. Data packets use six lanes, or three lanes when the narrow option is selected. Any lane slot that has no packet byte carries the idle control character.

The controller has two named states. In `S_IDLE` the block is ready and waits for a payload. The transition "accept" moves it to `S_EMIT`, where it sends one stripe per cycle. The transition "final stripe" returns it from `S_EMIT` to `S_IDLE`.

Top module: `lane_pkt_framer`

## Requirements
- R1: After reset the block is ready (`in_ready`=1) and `out_valid`=0. Every lane carries the idle character 0x1C with its K flag set.
- R2: Handshake timing.
  - A payload is accepted in any cycle where `in_valid` and `in_ready` are both high.
  - The first stripe appears in the cycle after acceptance.
  - `in_ready` stays low from that cycle through the last stripe. It returns high in the cycle after the last stripe.
- R3: Packet byte 0 is the start character 0xBC with K=1. Packet byte 1 is a type byte with K=0: 0x01 for a command, 0x02 for data.
- R4: Payload placement and masking.
  - Payload byte k is `in_payload[8k+7:8k]` and goes at packet position k+2, with K=0.
  - A data packet carries 72 payload bytes.
  - A command packet carries 5 payload bytes. Bits 39:35 of a command are forced to zero, and all higher input bits are dropped.
- R5: The CRC bytes have K=0. For a packet of length L, the CRC high byte is at position L-3 and the low byte is at position L-2. The CRC is computed as follows:
  - polynomial 0x1021, seed 0xFFFF;
  - most significant bit first, with no reflection and no final XOR;
  - over packet positions 0 to L-4, with the start character taken as the value 0xBC.
- R6: The last packet byte, at position L-1, is the end character 0xFD with K=1. This gives packet lengths of 10 bytes for a command and 77 bytes for data.
- R7: Packet byte i goes on lane i mod N in stripe floor(i/N). N is 3 for commands, 6 for data, and 3 for data with `in_narrow`=1. Lane l occupies `lane_byte[8l+7:8l]` and `lane_k[l]`.
- R8: Filler and the valid signal.
  - A slot with no packet byte carries 0x1C with K=1. This covers slots past the packet end and lanes numbered N or above.
  - `out_valid` is high in exactly the stripe cycles.
- R9: `in_valid` and `in_payload` changes during a packet do not alter the packet being sent.
- R10: A payload that is held valid is taken in the first ready cycle. Its CRC restarts from the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Payload offered |
| in_ready | output | 1 | Block can take a payload |
| in_is_data | input | 1 | 1 = data block, 0 = command |
| in_narrow | input | 1 | Data on 3 lanes instead of 6 |
| in_payload | input | 576 | Payload, byte 0 in the low bits |
| out_valid | output | 1 | A stripe is being driven |
| lane_byte | output | 48 | One byte per lane |
| lane_k | output | 6 | Control-character flag per lane |

## Verification
A reference model is compared against every lane on every cycle. It is tested with three packet shapes:
- A 10-byte command on 3 lanes, which leaves two idle slots in its final stripe.
- A 77-byte data packet on 6 lanes, which leaves one idle slot.
- The same data packet on 3 lanes, which shows that the lane count and not the packet kind sets the stripe mapping.

Commands with high input bits set show the masking of the dummy and unused bits. Payloads of all zeros and of a counting pattern give different CRC values, so a wrong seed or ordering shows up. The last two tests separate the handshake cases:
- An offer made while busy with different payload bytes is ignored.
- A payload held valid straight after a packet is taken back-to-back with a restarted CRC.

// File: rtl/lpf_pkg.sv
package lpf_pkg;
    localparam logic [7:0]  SYM_START = 8'hBC;   // K28.5
    localparam logic [7:0]  SYM_END   = 8'hFD;   // K29.7
    localparam logic [7:0]  SYM_IDLE  = 8'h1C;   // K28.0
    localparam logic [7:0]  TYPE_CMD  = 8'h01;
    localparam logic [7:0]  TYPE_DATA = 8'h02;
    localparam logic [15:0] CRC_POLY  = 16'h1021;
    localparam logic [15:0] CRC_SEED  = 16'hFFFF;

    typedef enum logic [0:0] {S_IDLE, S_EMIT} fr_state_e;

    function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int i = 0; i < 8; i++) begin
            r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/lpf_ctrl.sv
module lpf_ctrl
    import lpf_pkg::*;
#(
    parameter int IDX_W        = 7,
    parameter int LCNT_W       = 3,
    parameter int CMD_LEN      = 10,
    parameter int DATA_LEN     = 77,
    parameter int CMD_LANES    = 3,
    parameter int DATA_LANES   = 6,
    parameter int NARROW_LANES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_is_data,
    input  logic              in_narrow,
    output logic              in_ready,
    output logic              accept,
    output logic              emitting,
    output logic              last_cycle,
    output logic [IDX_W-1:0]  base,
    output logic [IDX_W-1:0]  pkt_len,
    output logic [LCNT_W-1:0] nlanes,
    output logic              is_data
);
    fr_state_e         state_q, state_d;
    logic [IDX_W-1:0]  base_q;
    logic              data_q, narrow_q;
    logic [IDX_W:0]    reach;

    assign nlanes  = data_q ? (narrow_q ? LCNT_W'(NARROW_LANES) : LCNT_W'(DATA_LANES))
                            : LCNT_W'(CMD_LANES);
    assign pkt_len = data_q ? IDX_W'(DATA_LEN) : IDX_W'(CMD_LEN);
    assign reach   = {1'b0, base_q} + (IDX_W+1)'(nlanes);
    assign base    = base_q;
    assign is_data = data_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (in_valid)   state_d = S_EMIT;   // accept
            S_EMIT: if (last_cycle) state_d = S_IDLE;   // final stripe
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            base_q   <= '0;
            data_q   <= 1'b0;
            narrow_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                base_q   <= '0;
                data_q   <= in_is_data;
                narrow_q <= in_narrow;
            end else if (emitting) begin
                base_q <= base_q + IDX_W'(nlanes);
            end
        end
    end

    // outputs
    always_comb begin
        in_ready   = 1'b0;
        emitting   = 1'b0;
        unique case (state_q)
            S_IDLE: in_ready = 1'b1;
            S_EMIT: emitting = 1'b1;
            default: in_ready = 1'b0;
        endcase
        accept     = in_ready && in_valid;
        last_cycle = emitting && (reach >= (IDX_W+1)'(pkt_len));
    end

    // R2
    accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (emitting && base_q == '0));
    // R2
    ready_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_cycle |=> in_ready);
    // R7
    base_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emitting |-> (base_q < pkt_len));
endmodule

// File: rtl/lpf_lanes.sv
module lpf_lanes
    import lpf_pkg::*;
#(
    parameter int MAX_LANES = 6,
    parameter int PAY_BYTES = 72,
    parameter int IDX_W     = 7,
    parameter int LCNT_W    = 3
) (
    input  logic                   emitting,
    input  logic [IDX_W-1:0]       base,
    input  logic [IDX_W-1:0]       pkt_len,
    input  logic [LCNT_W-1:0]      nlanes,
    input  logic                   is_data,
    input  logic [PAY_BYTES*8-1:0] payload,
    input  logic [15:0]            crc_in,
    output logic [MAX_LANES*8-1:0] lane_byte,
    output logic [MAX_LANES-1:0]   lane_k,
    output logic [15:0]            crc_out
);
    logic [15:0]      crc_run;
    logic [IDX_W-1:0] idx;
    int               pos;

    always_comb begin
        crc_run   = crc_in;
        lane_byte = '0;
        lane_k    = '0;
        idx       = '0;
        pos       = 0;
        for (int l = 0; l < MAX_LANES; l++) begin
            idx = base + IDX_W'(l);
            pos = int'(idx) - 2;
            lane_byte[l*8 +: 8] = SYM_IDLE;
            lane_k[l]           = 1'b1;
            if (emitting && (LCNT_W'(l) < nlanes) && (idx < pkt_len)) begin
                if (idx == '0) begin
                    lane_byte[l*8 +: 8] = SYM_START;
                    crc_run = crc16_byte(crc_run, SYM_START);
                end else if (idx == IDX_W'(1)) begin
                    lane_byte[l*8 +: 8] = is_data ? TYPE_DATA : TYPE_CMD;
                    lane_k[l] = 1'b0;
                    crc_run = crc16_byte(crc_run, is_data ? TYPE_DATA : TYPE_CMD);
                end else if (idx < pkt_len - IDX_W'(3)) begin
                    lane_byte[l*8 +: 8] = payload[pos*8 +: 8];
                    lane_k[l] = 1'b0;
                    crc_run = crc16_byte(crc_run, payload[pos*8 +: 8]);
                end else if (idx == pkt_len - IDX_W'(3)) begin
                    lane_byte[l*8 +: 8] = crc_run[15:8];
                    lane_k[l] = 1'b0;
                end else if (idx == pkt_len - IDX_W'(2)) begin
                    lane_byte[l*8 +: 8] = crc_run[7:0];
                    lane_k[l] = 1'b0;
                end else begin
                    lane_byte[l*8 +: 8] = SYM_END;
                end
            end
        end
        crc_out = crc_run;
    end
endmodule

// File: rtl/lane_pkt_framer.sv
module lane_pkt_framer
    import lpf_pkg::*;
#(
    parameter int CMD_BITS     = 35,
    parameter int CMD_BYTES    = 5,
    parameter int DATA_BYTES   = 72,
    parameter int CMD_LANES    = 3,
    parameter int DATA_LANES   = 6,
    parameter int NARROW_LANES = 3,
    localparam int FRAME_BYTES = 5,
    localparam int PAY_W       = DATA_BYTES * 8,
    localparam int CMD_LEN     = CMD_BYTES + FRAME_BYTES,
    localparam int DATA_LEN    = DATA_BYTES + FRAME_BYTES,
    localparam int MAX_LANES   = DATA_LANES,
    localparam int IDX_W       = $clog2(DATA_LEN + MAX_LANES + 1),
    localparam int LCNT_W      = $clog2(MAX_LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic                   in_is_data,
    input  logic                   in_narrow,
    input  logic [PAY_W-1:0]       in_payload,
    output logic                   out_valid,
    output logic [MAX_LANES*8-1:0] lane_byte,
    output logic [MAX_LANES-1:0]   lane_k
);
    localparam logic [PAY_W-1:0] CMD_MASK = {{(PAY_W-CMD_BITS){1'b0}}, {CMD_BITS{1'b1}}};

    logic              accept, emitting, last_cycle, is_data;
    logic [IDX_W-1:0]  base, pkt_len;
    logic [LCNT_W-1:0] nlanes;
    logic [PAY_W-1:0]  pay_q;
    logic [15:0]       crc_q, crc_next;

    lpf_ctrl #(
        .IDX_W(IDX_W), .LCNT_W(LCNT_W), .CMD_LEN(CMD_LEN), .DATA_LEN(DATA_LEN),
        .CMD_LANES(CMD_LANES), .DATA_LANES(DATA_LANES), .NARROW_LANES(NARROW_LANES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_data(in_is_data),
        .in_narrow(in_narrow), .in_ready(in_ready), .accept(accept),
        .emitting(emitting), .last_cycle(last_cycle), .base(base),
        .pkt_len(pkt_len), .nlanes(nlanes), .is_data(is_data)
    );

    lpf_lanes #(
        .MAX_LANES(MAX_LANES), .PAY_BYTES(DATA_BYTES), .IDX_W(IDX_W), .LCNT_W(LCNT_W)
    ) u_lanes (
        .emitting(emitting), .base(base), .pkt_len(pkt_len), .nlanes(nlanes),
        .is_data(is_data), .payload(pay_q), .crc_in(crc_q),
        .lane_byte(lane_byte), .lane_k(lane_k), .crc_out(crc_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pay_q <= '0;
            crc_q <= CRC_SEED;
        end else if (accept) begin
            pay_q <= in_is_data ? in_payload : (in_payload & CMD_MASK);
            crc_q <= CRC_SEED;
        end else if (emitting) begin
            crc_q <= crc_next;
        end
    end

    assign out_valid = emitting;

    // R10
    crc_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (crc_q == CRC_SEED));
    // R8
    idle_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (lane_k == {MAX_LANES{1'b1}}));
    // R9
    hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emitting && !$past(accept)) |-> $stable(pay_q));

    for (genvar l = 0; l < MAX_LANES; l++) begin : g_kchk
        // R6
        kchar_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lane_k[l] |-> (lane_byte[l*8 +: 8] == SYM_START ||
                           lane_byte[l*8 +: 8] == SYM_END ||
                           lane_byte[l*8 +: 8] == SYM_IDLE));
    end
endmodule

// File: tb/test_lane_pkt_framer.sv
`timescale 1ns/1ps
module test_lane_pkt_framer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_is_data = 1'b0;
    logic         in_narrow = 1'b0;
    logic [575:0] in_payload = '0;
    logic         out_valid;
    logic [47:0]  lane_byte;
    logic [5:0]   lane_k;

    int checks = 0;
    int errors = 0;
    bit live = 0;
    bit first = 1;
    bit exp_ready;

    logic [47:0] q_byte[$];
    logic [5:0]  q_k[$];
    logic [23:0] q_tag[$];

    always #2.5 clk = ~clk;

    lane_pkt_framer i_lane_pkt_framer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_is_data(in_is_data), .in_narrow(in_narrow), .in_payload(in_payload),
        .out_valid(out_valid), .lane_byte(lane_byte), .lane_k(lane_k)
    );

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int b = 7; b >= 0; b--) begin
            if (r[15] ^ d[b]) r = (r << 1) ^ 16'h1021;
            else              r = r << 1;
        end
        return r;
    endfunction

    // Reference model: build the packet (R3 R4 R5 R6), stripe it (R7), pad it (R8)
    task automatic push_packet(input bit d, input bit n, input logic [575:0] pay);
        logic [7:0]  pb[77];
        bit          pk[77];
        int          tg[77];
        int          len, nl, ncyc, np, i;
        logic [15:0] crc;
        logic [47:0] eb;
        logic [5:0]  ek;
        logic [23:0] et;
        np  = d ? 72 : 5;
        len = np + 5;
        nl  = d ? (n ? 3 : 6) : 3;
        pb[0] = 8'hBC; pk[0] = 1; tg[0] = 3;
        pb[1] = d ? 8'h02 : 8'h01; pk[1] = 0; tg[1] = 3;
        for (int j = 0; j < np; j++) begin
            pb[j+2] = pay[j*8 +: 8];
            if (!d && j == 4) pb[j+2] = pb[j+2] & 8'h07;   // R4 dummy bits zero
            pk[j+2] = 0; tg[j+2] = 4;
        end
        crc = 16'hFFFF;
        for (int j = 0; j < len - 3; j++) crc = crc_upd(crc, pb[j]);
        pb[len-3] = crc[15:8]; pk[len-3] = 0; tg[len-3] = 5;
        pb[len-2] = crc[7:0];  pk[len-2] = 0; tg[len-2] = 5;
        pb[len-1] = 8'hFD;     pk[len-1] = 1; tg[len-1] = 6;
        ncyc = (len + nl - 1) / nl;
        for (int c = 0; c < ncyc; c++) begin
            for (int l = 0; l < 6; l++) begin
                i = c * nl + l;
                if (l < nl && i < len) begin
                    eb[l*8 +: 8] = pb[i]; ek[l] = pk[i]; et[l*4 +: 4] = 4'(tg[i]);
                end else begin
                    eb[l*8 +: 8] = 8'h1C; ek[l] = 1'b1; et[l*4 +: 4] = 4'd8;
                end
            end
            q_byte.push_back(eb); q_k.push_back(ek); q_tag.push_back(et);
        end
    endtask

    task automatic check_cycle();
        logic [47:0] eb;
        logic [5:0]  ek;
        logic [23:0] et;
        bit          ev;
        if (q_byte.size() != 0) begin
            eb = q_byte.pop_front(); ek = q_k.pop_front(); et = q_tag.pop_front();
            ev = 1; exp_ready = 0;
        end else begin
            eb = {6{8'h1C}}; ek = 6'h3F; et = {6{first ? 4'd1 : 4'd8}};
            ev = 0; exp_ready = 1;
        end
        for (int l = 0; l < 6; l++) begin
            checks++;
            if (lane_byte[l*8 +: 8] !== eb[l*8 +: 8] || lane_k[l] !== ek[l]) begin
                errors++;
                $display("FAIL R%0d/R7 lane %0d: got %h k%0b expected %h k%0b",
                         et[l*4 +: 4], l, lane_byte[l*8 +: 8], lane_k[l], eb[l*8 +: 8], ek[l]);
            end
        end
        checks++;
        if (out_valid !== ev) begin
            errors++;
            $display("FAIL R8 out_valid: got %0b expected %0b", out_valid, ev);
        end
        checks++;
        if (in_ready !== exp_ready) begin
            errors++;
            $display("FAIL %s in_ready: got %0b expected %0b", first ? "R1" : "R2",
                     in_ready, exp_ready);
        end
        first = 0;
    endtask

    // One cycle: check the outputs, then drive the next inputs (R2 acceptance)
    task automatic step(input bit v, input bit d, input bit n, input logic [575:0] pay,
                        output bit taken);
        @(negedge clk);
        check_cycle();
        in_valid = v; in_is_data = d; in_narrow = n; in_payload = pay;
        taken = v && exp_ready;
        if (taken) push_packet(d, n, pay);
    endtask

    task automatic send(input bit d, input bit n, input logic [575:0] pay);
        bit t;
        t = 0;
        while (!t) step(1, d, n, pay, t);
    endtask

    task automatic quiet(input int cycles);
        bit t;
        for (int c = 0; c < cycles; c++) step(0, 0, 0, '0, t);
    endtask

    function automatic logic [575:0] pattern(input int seed);
        logic [575:0] p;
        for (int j = 0; j < 72; j++) p[j*8 +: 8] = 8'((seed + j * 37) ^ (j << 2));
        return p;
    endfunction

    initial begin
        bit t;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: idle after reset
        quiet(2);
        // R4: command with high bits set, masking of dummy and unused bits
        send(0, 0, {576{1'b1}});
        quiet(6);
        // R5: all-zero command payload
        send(0, 0, '0);
        quiet(5);
        // R7: data packet on 6 lanes
        send(1, 0, pattern(5));
        quiet(15);
        // R7: data packet on 3 lanes; R9: offers while busy are ignored
        send(1, 1, pattern(77));
        for (int c = 0; c < 5; c++) step(1, 0, 0, pattern(200 + c), t);
        quiet(24);
        // R10: back-to-back, payload held valid through busy cycles
        send(1, 0, pattern(9));
        send(0, 0, pattern(42));
        send(1, 1, pattern(13));
        quiet(30);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule